// File: doc/BRIEF.md
# Iterative CORDIC Vector Rotator

This block turns a signed two-component vector through a signed angle using nothing but shifts, additions and subtractions. In a field-oriented motor drive it does the frame change between stator-fixed and rotor-fixed axes in both directions. One datapath serves both directions: a control input flips the sign of the angle before any other processing.

A one-cycle start strobe captures the vector, the angle and the direction bit. A coarse quarter-turn rotation is applied first. The sign of the angle picks +90° or −90°, and the residual angle left after that step lies within ±90°. Sixteen micro-rotations follow, one per clock. Each one moves the vector by ±arctan(2^-i) and drives the residual angle towards zero. The result is scaled by the fixed CORDIC gain of about 1.6468 and appears on registered outputs together with a one-cycle completion flag. The outputs hold that result until the next operation completes. The block does no gain correction.

Angles use a binary full-turn scale: 65536 units per revolution, with the signed 16-bit input covering −π (code −32768) up to just below +π. The outputs are two bits wider than the inputs, so the gain cannot overflow them.

Top module: `vec_rotator`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and both `x_out` and `y_out` are 0 until an operation completes.
- R2: With `inverse` = 0 the outputs equal K·(x·cosθ − y·sinθ) and K·(x·sinθ + y·cosθ) within ±48 LSB. Here K = 1.646760258, θ = `theta`·π/32768 and `theta` is two's complement.
- R3: R2 holds over the whole angle range, including |θ| > 90°, `theta` = 32767 and `theta` = −32768 (−π), through the quarter-turn pre-rotation.
- R4: `done` is high for exactly one cycle, 16 clock cycles after the edge that samples `start`.
- R5: With `inverse` = 1 the rotation is by −θ to the same accuracy, including `theta` = −32768 (a rotation by +π).
- R6: A `start` pulse while an operation is in progress, including on the clock edge of the final micro-rotation, is ignored. The running result, its timing and the later `done` activity are unaffected.
- R7: A `start` sampled in the cycle where `done` is high is accepted, so operations can run back to back.
- R8: `x_out` and `y_out` keep the last result unchanged until the next operation completes, whatever the inputs do.
- R9: Full-scale inputs (−32768, −32768) rotated by 45° give the correct result in the 18-bit outputs without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; captures the inputs when idle |
| inverse | input | 1 | 1 = rotate by the negated angle |
| x_in | input | 16 | First vector component, signed |
| y_in | input | 16 | Second vector component, signed |
| theta | input | 16 | Signed angle, 65536 units per turn |
| x_out | output | 18 | Rotated first component times the gain, signed |
| y_out | output | 18 | Rotated second component times the gain, signed |
| done | output | 1 | One-cycle pulse when the outputs take a new result |

## Verification
Two events can fall on the same clock edge: the completion of one operation and a new start request. Their meaning differs by one cycle. A request that arrives on the edge of the last micro-rotation must be dropped. A request arriving while `done` is high must launch a new operation. The bench provokes both cases. It raises `start` with different operands exactly one cycle before completion, and confirms that the old result is delivered and that no further `done` follows. It then raises `start` during the `done` cycle, and expects the new operands' result exactly 16 cycles later, with the earlier result still visible while `done` is high.

// File: rtl/vrot_pkg.sv
package vrot_pkg;
  // angle scale: 65536 units per full turn, one extra bit of headroom internally
  localparam int ANG_W = 16;
  localparam int ZW    = ANG_W + 1;
  localparam logic signed [ZW-1:0] QUARTER = 17'sd16384;

  // arctan(2^-i) in angle units, rounded to the nearest unit
  function automatic logic signed [ZW-1:0] atan_step(input int i);
    logic signed [ZW-1:0] v;
    case (i)
      0:  v = 17'sd8192;
      1:  v = 17'sd4836;
      2:  v = 17'sd2555;
      3:  v = 17'sd1297;
      4:  v = 17'sd651;
      5:  v = 17'sd326;
      6:  v = 17'sd163;
      7:  v = 17'sd81;
      8:  v = 17'sd41;
      9:  v = 17'sd20;
      10: v = 17'sd10;
      11: v = 17'sd5;
      12: v = 17'sd3;
      13: v = 17'sd1;
      14: v = 17'sd1;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/vrot_prerot.sv
module vrot_prerot
  import vrot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IW     = DATA_W + 2
) (
  input  logic                     inverse,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  input  logic signed [ANG_W-1:0]  theta,
  output logic signed [IW-1:0]     x0,
  output logic signed [IW-1:0]     y0,
  output logic signed [ZW-1:0]     z0
);
  localparam int GB = IW - DATA_W;

  logic signed [ZW-1:0] th_e;
  logic signed [ZW-1:0] ang;
  logic signed [IW-1:0] xe;
  logic signed [IW-1:0] ye;

  always_comb begin
    th_e = {theta[ANG_W-1], theta};
    ang  = inverse ? -th_e : th_e;
    xe   = {{GB{x_in[DATA_W-1]}}, x_in};
    ye   = {{GB{y_in[DATA_W-1]}}, y_in};
    if (!ang[ZW-1]) begin
      x0 = -ye;
      y0 = xe;
      z0 = ang - QUARTER;
    end else begin
      x0 = ye;
      y0 = -xe;
      z0 = ang + QUARTER;
    end
  end

  // residual angle must lie inside the convergence span of the micro-rotations
  always_comb begin
    assert_prerot_span_R3: assert (z0 <= QUARTER && z0 >= -QUARTER);
  end
endmodule

// File: rtl/vrot_step.sv
module vrot_step
  import vrot_pkg::*;
#(
  parameter int IW = 18,
  parameter int CW = 4
) (
  input  logic signed [IW-1:0] x,
  input  logic signed [IW-1:0] y,
  input  logic signed [ZW-1:0] z,
  input  logic [CW-1:0]        idx,
  output logic signed [IW-1:0] xn,
  output logic signed [IW-1:0] yn,
  output logic signed [ZW-1:0] zn
);
  logic signed [IW-1:0] xs;
  logic signed [IW-1:0] ys;
  logic signed [ZW-1:0] at;

  always_comb begin
    xs = x >>> idx;
    ys = y >>> idx;
    at = atan_step(int'(idx));
    if (!z[ZW-1]) begin
      xn = x - ys;
      yn = y + xs;
      zn = z - at;
    end else begin
      xn = x + ys;
      yn = y - xs;
      zn = z + at;
    end
  end
endmodule

// File: rtl/vrot_seq.sv
module vrot_seq #(
  parameter int ITERS = 16,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          busy,
  output logic          fin,
  output logic [CW-1:0] idx,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  always_comb begin
    last   = (cnt_q == LAST);
    load   = start && !busy_q;
    fin    = busy_q && last;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign idx  = cnt_q;
  assign done = done_q;

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q) && !busy_q);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last && start) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/vec_rotator.sv
module vec_rotator
  import vrot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ITERS  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       inverse,
  input  logic signed [DATA_W-1:0]   x_in,
  input  logic signed [DATA_W-1:0]   y_in,
  input  logic signed [ANG_W-1:0]    theta,
  output logic signed [DATA_W+1:0]   x_out,
  output logic signed [DATA_W+1:0]   y_out,
  output logic                       done
);
  localparam int IW = DATA_W + 2;
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic                 load, busy, fin;
  logic [CW-1:0]        idx;
  logic signed [IW-1:0] x0, y0, xn, yn;
  logic signed [ZW-1:0] z0, zn;
  logic signed [IW-1:0] x_q, x_d, y_q, y_d, xo_q, xo_d, yo_q, yo_d;
  logic signed [ZW-1:0] z_q, z_d;

  vrot_prerot #(.DATA_W(DATA_W), .IW(IW)) u_pre (
    .inverse(inverse), .x_in(x_in), .y_in(y_in), .theta(theta),
    .x0(x0), .y0(y0), .z0(z0)
  );

  vrot_seq #(.ITERS(ITERS), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .busy(busy), .fin(fin), .idx(idx), .done(done)
  );

  vrot_step #(.IW(IW), .CW(CW)) u_step (
    .x(x_q), .y(y_q), .z(z_q), .idx(idx),
    .xn(xn), .yn(yn), .zn(zn)
  );

  always_comb begin
    x_d  = x_q;
    y_d  = y_q;
    z_d  = z_q;
    xo_d = xo_q;
    yo_d = yo_q;
    if (load) begin
      x_d = x0;
      y_d = y0;
      z_d = z0;
    end else if (busy) begin
      x_d = xn;
      y_d = yn;
      z_d = zn;
    end
    if (fin) begin
      xo_d = xn;
      yo_d = yn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      z_q  <= '0;
      xo_q <= '0;
      yo_q <= '0;
    end else begin
      x_q  <= x_d;
      y_q  <= y_d;
      z_q  <= z_d;
      xo_q <= xo_d;
      yo_q <= yo_d;
    end
  end

  assign x_out = xo_q;
  assign y_out = yo_q;

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(x_out) && $stable(y_out)));

  assert_residual_small_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (z_q <= 17'sd8 && z_q >= -17'sd8));
endmodule

// File: tb/sim_vec_rotator.sv
module sim_vec_rotator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic inverse = 1'b0;
  logic signed [15:0] x_in = '0;
  logic signed [15:0] y_in = '0;
  logic signed [15:0] theta = '0;
  logic signed [17:0] x_out, y_out;
  logic done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;
  localparam int TOL = 48;
  localparam int LAT = 16;

  always #10 clk = ~clk;

  vec_rotator u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .inverse(inverse),
    .x_in(x_in), .y_in(y_in), .theta(theta),
    .x_out(x_out), .y_out(y_out), .done(done)
  );

  task automatic chk(string req, string what, int act, int exp, int tol);
    n_chk++;
    if (act - exp > tol || exp - act > tol) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input int x, input int y, input int th, input bit inv,
                       output int ex, output int ey);
    real a, k;
    k = 1.646760258;
    a = th * 3.14159265358979 / 32768.0;
    if (inv) a = -a;
    ex = $rtoi(k * (x * $cos(a) - y * $sin(a)));
    ey = $rtoi(k * (x * $sin(a) + y * $cos(a)));
  endtask

  task automatic drive(input int x, input int y, input int th, input bit inv);
    x_in = 16'(x);
    y_in = 16'(y);
    theta = 16'(th);
    inverse = inv;
  endtask

  task automatic launch(input int x, input int y, input int th, input bit inv);
    @(negedge clk);
    drive(x, y, th, inv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_result(string req, int x, int y, int th, bit inv);
    int ex, ey;
    model(x, y, th, inv, ex, ey);
    chk(req, "x_out", int'(x_out), ex, TOL);
    chk(req, "y_out", int'(y_out), ey, TOL);
  endtask

  task automatic run_rot(string req, int x, int y, int th, bit inv);
    int n;
    launch(x, y, th, inv);
    wait_done(n);
    chk("R4", "latency", n, LAT, 0);
    check_result(req, x, y, th, inv);
    @(negedge clk);
    chk("R4", "done width", int'(done), 0, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0, 0);
    chk("R1", "x_out in reset", int'(x_out), 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "y_out after reset", int'(y_out), 0, 0);
    chk("R1", "done after reset", int'(done), 0, 0);
  endtask

  task automatic t_forward;
    run_rot("R2", 10000, 0, 0, 1'b0);
    run_rot("R2", 10000, 5000, 8192, 1'b0);
    run_rot("R2", -7000, 12000, -5000, 1'b0);
  endtask

  task automatic t_wide;
    run_rot("R3", -12000, 7000, 30000, 1'b0);
    run_rot("R3", 20000, -3000, -25000, 1'b0);
    run_rot("R3", 15000, 4000, -32768, 1'b0);
    run_rot("R3", 15000, 4000, 32767, 1'b0);
  endtask

  task automatic t_inverse;
    run_rot("R5", 10000, 2000, 12000, 1'b1);
    run_rot("R5", -9000, 11000, -20000, 1'b1);
    run_rot("R5", 15000, 4000, -32768, 1'b1);
  endtask

  task automatic t_fullscale;
    run_rot("R9", -32768, -32768, 8192, 1'b0);
    run_rot("R9", 32767, -32768, -8192, 1'b0);
  endtask

  task automatic t_busy_start;
    int n, spurious;
    launch(9000, -4000, 5000, 1'b0);
    n = 0;
    repeat (4) begin @(negedge clk); n++; end
    drive(-20000, 15000, -12000, 1'b1);
    start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk("R6", "latency with mid start", n, LAT, 0);
    check_result("R6", 9000, -4000, 5000, 1'b0);
    launch(-6000, 3000, 20000, 1'b0);
    n = 0;
    repeat (LAT - 1) begin @(negedge clk); n++; end
    drive(25000, 25000, 1000, 1'b0);
    start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    chk("R6", "done with start on last step", int'(done), 1, 0);
    check_result("R6", -6000, 3000, 20000, 1'b0);
    spurious = 0;
    repeat (24) begin
      @(negedge clk);
      if (done) spurious++;
    end
    chk("R6", "extra done count", spurious, 0, 0);
    check_result("R6", -6000, 3000, 20000, 1'b0);
  endtask

  task automatic t_back2back;
    int n;
    launch(12000, 3000, 4000, 1'b0);
    wait_done(n);
    chk("R7", "first latency", n, LAT, 0);
    drive(-5000, -14000, -15000, 1'b0);
    start = 1'b1;
    check_result("R7", 12000, 3000, 4000, 1'b0);
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk("R7", "second latency", n, LAT, 0);
    check_result("R7", -5000, -14000, -15000, 1'b0);
  endtask

  task automatic t_hold;
    int hx, hy;
    run_rot("R8", 8000, 8000, 16384, 1'b0);
    hx = int'(x_out);
    hy = int'(y_out);
    drive(-30000, 30000, 100, 1'b1);
    repeat (6) @(negedge clk);
    chk("R8", "x_out held", int'(x_out), hx, 0);
    chk("R8", "y_out held", int'(y_out), hy, 0);
    chk("R8", "no done", int'(done), 0, 0);
  endtask

  initial begin
    t_reset();
    t_forward();
    t_wide();
    t_inverse();
    t_fullscale();
    t_busy_start();
    t_back2back();
    t_hold();
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule